// File: doc/BRIEF.md
# Signed Operand Normalizer

This block prepares one two's complement operand for a radix-2 SRT divider. It widens the operand by sign extension from its own width to a common working width, so that a dividend and a divisor of different sizes reach the divider at one size. It then moves the value left until its two top bits differ. It reports how many positions it moved the value, so that the quotient and remainder can be scaled back after the division.

The value stays signed throughout. No magnitude is taken and no guard bit is added. A leading-sign detector finds the first bit below the sign that differs from the sign. A logarithmic barrel shifter then applies that distance in a single pass. One parameter selects the timing. At 0 the path is purely combinational and the valid strobe is the start strobe itself. At 1 or more there is exactly one register stage, which captures the result on the start strobe.

Top module: `opnd_normalizer`

## Requirements
- R1: The normalized output, shifted right arithmetically by the reported shift count, equals the input operand sign-extended from ORIG_W to WORK_W bits.
- R2: For any operand other than 0 and -1, the two most significant bits of the normalized output differ: they read 01 or 10.
- R3: The shift count equals the number of consecutive bits, starting at bit WORK_W-2 and moving downward, that equal the sign bit of the sign-extended operand. It is given as an unsigned value of clog2(WORK_W) bits.
- R4: For operand 0 the shift count is WORK_W-1 and the output is all zeros. For operand -1 the shift count is WORK_W-1 and the output is a 1 followed by WORK_W-1 zeros.
- R5: With LATENCY = 0, valid equals start in the same cycle, and the normalized output and shift count follow the operand combinationally.
- R6: With LATENCY = 1, valid is high exactly in the cycle after a cycle with start high. In that cycle the output and count belong to the operand that was present with start.
- R7: With a register stage present, the output and count hold their values in every cycle that follows a cycle without start, whatever the operand does.
- R8: Asynchronous reset (active high) clears valid, the normalized output and the shift count to zero.
- R9: A LATENCY above 1 behaves exactly like LATENCY = 1: one stage and one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| start_i | input | 1 | One-cycle start strobe |
| operand_i | input | ORIG_W | Signed operand |
| norm_o | output | WORK_W | Normalized signed operand |
| shift_o | output | clog2(WORK_W) | Number of left shifts applied |
| valid_o | output | 1 | Result valid strobe |

## Verification
With LATENCY = 0, the results are due in the same cycle as start. The bench reads them 1 ns after it drives the operand. With one register stage, valid, the normalized value and the count are due at the first rising edge after start. The bench compares them at the following falling edge against a model register that it updates on that same edge. In cycles without start, the model keeps its old value, so a hold violation shows up at once. Instances with LATENCY = 0, 1 and 3 run the same stimulus side by side: directed extremes (0, -1, the most positive value, the most negative value, single bits) and then random operands with random start strobes.

// File: rtl/norm_pkg.sv
package norm_pkg;
  // number of register stages actually built for a latency setting
  function automatic int eff_stages(input int lat);
    return (lat > 0) ? 1 : 0;
  endfunction

  // width of the shift-count field for a working width
  function automatic int cnt_width(input int w);
    return (w < 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/opnd_sext.sv
module opnd_sext #(
  parameter int ORIG_W = 12,
  parameter int WORK_W = 16
) (
  input  logic [ORIG_W-1:0] in_i,
  output logic [WORK_W-1:0] out_o
);
  localparam int EXT_W = WORK_W - ORIG_W;
  generate
    if (EXT_W == 0) begin : g_same
      assign out_o = in_i;
    end else begin : g_ext
      assign out_o = {{EXT_W{in_i[ORIG_W-1]}}, in_i};
    end
  endgenerate
endmodule

// File: rtl/lead_sign_detect.sv
module lead_sign_detect #(
  parameter int W  = 16,
  parameter int CW = 4
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] cnt_o
);
  // distance from the sign bit to the first bit that differs from it
  function automatic logic [CW-1:0] sign_run(input logic [W-1:0] v);
    logic [CW-1:0] c;
    logic          hit;
    c   = CW'(W - 1);
    hit = 1'b0;
    for (int i = 0; i < W - 1; i++) begin
      if (!hit && (v[W-2-i] != v[W-1])) begin
        c   = CW'(i);
        hit = 1'b1;
      end
    end
    return c;
  endfunction

  assign cnt_o = sign_run(val_i);
endmodule

// File: rtl/barrel_shl.sv
module barrel_shl #(
  parameter int W  = 16,
  parameter int CW = 4
) (
  input  logic [W-1:0]  val_i,
  input  logic [CW-1:0] amt_i,
  output logic [W-1:0]  val_o
);
  logic [W-1:0] lvl [CW+1];
  assign lvl[0] = val_i;
  generate
    for (genvar k = 0; k < CW; k++) begin : g_lvl
      assign lvl[k+1] = amt_i[k] ? (lvl[k] << (1 << k)) : lvl[k];
    end
  endgenerate
  assign val_o = lvl[CW];
endmodule

// File: rtl/opnd_normalizer.sv
module opnd_normalizer #(
  parameter int ORIG_W  = 12,
  parameter int WORK_W  = 16,
  parameter int LATENCY = 1,
  localparam int CNT_W  = norm_pkg::cnt_width(WORK_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ORIG_W-1:0] operand_i,
  output logic [WORK_W-1:0] norm_o,
  output logic [CNT_W-1:0]  shift_o,
  output logic              valid_o
);
  localparam int STAGES = norm_pkg::eff_stages(LATENCY);

  // named internal events
  logic [WORK_W-1:0] ext_w;
  logic [CNT_W-1:0]  run_w;
  logic [WORK_W-1:0] shf_w;

  opnd_sext #(.ORIG_W(ORIG_W), .WORK_W(WORK_W)) u_sext (
    .in_i (operand_i),
    .out_o(ext_w)
  );

  lead_sign_detect #(.W(WORK_W), .CW(CNT_W)) u_lsd (
    .val_i(ext_w),
    .cnt_o(run_w)
  );

  barrel_shl #(.W(WORK_W), .CW(CNT_W)) u_shl (
    .val_i(ext_w),
    .amt_i(run_w),
    .val_o(shf_w)
  );

  generate
    if (STAGES == 0) begin : g_comb
      assign norm_o  = shf_w;
      assign shift_o = run_w;
      assign valid_o = start_i;

      // R1
      restore_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (($signed(norm_o) >>> shift_o) == $signed(ext_w)));
      // R2
      normalized_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && (shift_o != CNT_W'(WORK_W - 1))) |->
        (norm_o[WORK_W-1] != norm_o[WORK_W-2]));
    end else begin : g_reg
      logic [WORK_W-1:0] q_norm;
      logic [CNT_W-1:0]  q_cnt;
      logic              q_vld;

      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          q_norm <= '0;
          q_cnt  <= '0;
          q_vld  <= 1'b0;
        end else begin
          q_vld <= start_i;
          if (start_i) begin
            q_norm <= shf_w;
            q_cnt  <= run_w;
          end
        end
      end

      assign norm_o  = q_norm;
      assign shift_o = q_cnt;
      assign valid_o = q_vld;

      // R1
      restore_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (($signed(norm_o) >>> shift_o) == $signed($past(ext_w))));
      // R2
      normalized_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && (shift_o != CNT_W'(WORK_W - 1))) |->
        (norm_o[WORK_W-1] != norm_o[WORK_W-2]));
      // R6
      valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        $past(start_i) |-> valid_o);
      // R7
      hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(start_i) |-> ($stable(norm_o) && $stable(shift_o) && !valid_o));
    end
  endgenerate
endmodule

// File: tb/opnd_normalizer_test.sv
`timescale 1ns/1ps
module opnd_normalizer_test;
  localparam int OW = 12;
  localparam int WW = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [OW-1:0] op = '0;
  logic          done = 1'b0;
  int            n_chk = 0;
  int            n_bad = 0;

  logic [WW-1:0] n1, n0, n3;
  logic [CW-1:0] c1, c0, c3;
  logic          v1, v0, v3;

  always #2.5 clk = ~clk;

  opnd_normalizer #(.ORIG_W(OW), .WORK_W(WW), .LATENCY(1)) uut (
    .clk(clk), .rst(rst), .start_i(start), .operand_i(op),
    .norm_o(n1), .shift_o(c1), .valid_o(v1));
  opnd_normalizer #(.ORIG_W(OW), .WORK_W(WW), .LATENCY(0)) uut_comb (
    .clk(clk), .rst(rst), .start_i(start), .operand_i(op),
    .norm_o(n0), .shift_o(c0), .valid_o(v0));
  opnd_normalizer #(.ORIG_W(OW), .WORK_W(WW), .LATENCY(3)) uut_lat3 (
    .clk(clk), .rst(rst), .start_i(start), .operand_i(op),
    .norm_o(n3), .shift_o(c3), .valid_o(v3));

  // behavioural reference: shift one place at a time while top bits agree
  function automatic int ref_cnt(input logic [OW-1:0] o);
    int v, c;
    v = int'($signed(o));
    c = 0;
    while (c < WW - 1 && (((v >> (WW - 1 - c)) & 1) == ((v >> (WW - 2 - c)) & 1)))
      c++;
    return c;
  endfunction

  function automatic logic [WW-1:0] ref_norm(input logic [OW-1:0] o);
    logic [WW-1:0] v;
    v = WW'($signed(o));
    return v << ref_cnt(o);
  endfunction

  // one-stage model, updated on the same edge as the design
  logic [WW-1:0] e_n;
  logic [CW-1:0] e_c;
  logic          e_v;
  always @(posedge clk or posedge rst) begin
    if (rst) begin
      e_n <= '0; e_c <= '0; e_v <= 1'b0;
    end else begin
      e_v <= start;
      if (start) begin
        e_n <= ref_norm(op);
        e_c <= CW'(ref_cnt(op));
      end
    end
  end

  task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_regs();
    string t;
    t = e_v ? "R6" : "R7";
    chk({t, " valid"}, WW'(v1), WW'(e_v));
    chk({t, " norm"},  n1, e_n);
    chk({t, " shift"}, WW'(c1), WW'(e_c));
    chk("R9 valid", WW'(v3), WW'(e_v));
    chk("R9 norm",  n3, e_n);
    chk("R9 shift", WW'(c3), WW'(e_c));
  endtask

  task automatic apply(input logic s, input logic [OW-1:0] o);
    logic deg;
    @(negedge clk);
    check_regs();
    start = s;
    op    = o;
    #1;
    deg = (o == '0) || (o == '1);
    chk("R5 valid", WW'(v0), WW'(s));
    chk(deg ? "R4 norm" : "R1 norm", n0, ref_norm(o));
    chk(deg ? "R4 shift" : "R3 shift", WW'(c0), WW'(ref_cnt(o)));
    if (!deg) chk("R2 top bits differ", WW'(n0[WW-1] ^ n0[WW-2]), WW'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 valid", WW'(v1), '0);
    chk("R8 norm",  n1, '0);
    chk("R8 shift", WW'(c1), '0);
    chk("R8 lat3 valid", WW'(v3), '0);
    rst = 1'b0;
    apply(1'b1, 12'h001);
    apply(1'b1, 12'hFFF);
    apply(1'b1, 12'h000);
    apply(1'b1, 12'h7FF);
    apply(1'b1, 12'h800);
    apply(1'b0, 12'h400);
    apply(1'b0, 12'h123);
    apply(1'b1, 12'h400);
    apply(1'b1, 12'h005);
    apply(1'b1, 12'hFFB);
    apply(1'b1, 12'hFFE);
    for (int i = 0; i < 400; i++)
      apply(1'($urandom_range(0, 1)), OW'($urandom));
    apply(1'b0, 12'h000);
    apply(1'b0, 12'h000);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule